// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a 256-byte memory that answers on a two-wire serial bus (I2C). It watches the bus clock and data lines and pulls the data line low when it acknowledges or sends a zero bit. A bus master writes data in two ways. In a single-byte write it sends one data byte. In a page write it sends up to sixteen data bytes, which land in a sixteen-entry staging buffer. The master reads data by setting the word pointer and then clocking out bytes, or by reading from wherever the pointer already stands.

Staged bytes move into the storage array only after a STOP that follows a whole byte. The array then runs a timed internal programming window. During that window the block does not answer its own bus address. A write-protect input can veto the commit, and so can a low-supply lockout input driven by the supervisor's reset state. Under either veto, data bytes are still acknowledged but nothing is written.

The system clock oversamples SCL and SDA through a synchronizer. The bus must therefore run several times slower than the system clock.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: Data written to a word address is read back unchanged from that address. All 256 addresses are reachable, and after reset every location holds 8'hFF.
- R2: A select byte is acknowledged only when bits [7:4] equal 4'b1010 and bits [3:1] equal `chip_sel_i`. Bit 0 chooses read (1) or write (0). On any other select byte the data line is never pulled.
- R3: If `wp_i` is high when the STOP arrives, the array is left unchanged. Data bytes are still acknowledged, and no programming window starts.
- R4: If `vlow_i` is high when the STOP arrives, the array is left unchanged. Data bytes are still acknowledged, and no programming window starts. `vlow_i` also gates each individual array write.
- R5: The data line is only ever pulled low through `sda_pull_o`. The pull changes only while SCL is low, and `sda_pull_o` is 0 after reset.
- R6: In a page write, the byte offset (word address bits [3:0]) increments and wraps inside the sixteen-byte page. Bits [7:4] stay fixed.
- R7: Data bytes beyond the sixteenth overwrite the buffer entries at the wrapped offsets, so the later byte wins.
- R8: A commit happens only on a STOP that follows at least one complete data byte. Two cases discard the transaction and start no programming window: a STOP in the middle of a data byte, and a write that carries only a word address.
- R9: For `WR_CYCLES` clocks after a commit starts, the block does not acknowledge its select byte. Once the window ends, it acknowledges again.
- R10: A read returns successive bytes with the word pointer incrementing across the whole space, wrapping from 8'hFF to 8'h00. The read ends when the master answers NACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| chip_sel_i | input | 3 | Strapped select bits compared with select byte bits [3:1] |
| wp_i | input | 1 | Write protect, high blocks commits |
| vlow_i | input | 1 | Supply below threshold, high blocks commits |
| sda_pull_o | output | 1 | Pull-down enable for the open-drain data line |

## Verification
Two functions can fall on the same cycle: the STOP that starts a commit, and the sampling of the write-protect and lockout inputs that decide whether the commit may run. The bench holds each veto input high across the STOP. It then judges the result at the ports in two ways. It checks that an immediately following select byte is acknowledged, which shows that no programming window was opened. It checks that a read-back returns the old byte. A second overlap is a select byte arriving while the programming window is still counting. The bench sends one a few clocks after a commit's STOP and expects a NACK, then repeats it after the window closes and expects an ACK.

// File: rtl/eep_pkg.sv
// Package: shared protocol phase encoding for the serial memory slave.
// Assumes: one byte is eight bits on the bus; the ninth clock is the acknowledge slot.
package eep_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DEV   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_WDATA = 3'd3,
        PH_RDATA = 3'd4
    } phase_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/eep_bus_sync.sv
// Module: eep_bus_sync
// Synchronizes the bus clock and data lines into the system clock domain and
// flags clock edges and START/STOP conditions.
// Assumes: the system clock runs well above the bus clock, and the master does
// not move SDA on the same system cycle as an SCL edge.
module eep_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    // Purpose: multi-stage synchronizer chain, released bus idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Purpose: one-cycle history for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_page_buf.sv
// Module: eep_page_buf
// Staging buffer for one page of write data with a per-entry valid mask.
// Assumes: clear and write are never requested in the same cycle.
module eep_page_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic [DEPTH-1:0] valid
);
    logic [DW-1:0] ent [DEPTH];

    // Purpose: per-entry storage with its own valid flag.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g]   <= '0;
                valid[g] <= 1'b0;
            end else if (clr) begin
                valid[g] <= 1'b0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                ent[g]   <= wr_data;
                valid[g] <= 1'b1;
            end
        end
    end

    assign rd_data = ent[rd_idx];
endmodule

// File: rtl/eep_wcycle.sv
// Module: eep_wcycle
// Times the internal programming window; during its first DEPTH cycles it
// steps a slot index so the buffer drains one entry per cycle.
// Assumes: WR_CYCLES >= DEPTH; start is a single-cycle pulse.
module eep_wcycle #(
    parameter int WR_CYCLES = 2000,
    parameter int DEPTH     = 16,
    localparam int CW       = $clog2(WR_CYCLES + 1),
    localparam int IW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          slot_we,
    output logic [IW-1:0] slot_idx
);
    localparam logic [CW-1:0] FULL  = CW'(WR_CYCLES);
    localparam logic [CW-1:0] DRAIN = CW'(DEPTH);

    logic [CW-1:0] remain;
    logic [CW-1:0] elapsed;

    // Purpose: load the window length on start, count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= FULL;
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign busy     = (remain != '0);
    assign elapsed  = FULL - remain;
    assign slot_we  = busy && (elapsed < DRAIN);
    assign slot_idx = elapsed[IW-1:0];
endmodule

// File: rtl/eep_array.sv
// Module: eep_array
// Byte storage array with one synchronous write port and one combinational
// read port; reset leaves every location in the erased state (all ones).
// Assumes: a single writer.
module eep_array #(
    parameter int AW = 8,
    parameter int DW = 8,
    localparam int WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    // Purpose: erase on reset, otherwise write one word when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_eeprom_slave.sv
// Module: i2c_eeprom_slave
// Two-wire serial memory slave: select-byte match, word pointer, page staging,
// STOP-triggered commit with write-protect and low-supply veto, timed busy
// window, and auto-incrementing reads.
// Assumes: SCL is slower than clk / (4 * SYNC_STAGES); ADDR_W <= 8.
module i2c_eeprom_slave #(
    parameter int          ADDR_W      = 8,
    parameter int          PAGE_DEPTH  = 16,
    parameter int          WR_CYCLES   = 2000,
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  DEV_TYPE    = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_sel_i,
    input  logic       wp_i,
    input  logic       vlow_i,
    output logic       sda_pull_o
);
    import eep_pkg::*;

    localparam int OFF_W = $clog2(PAGE_DEPTH);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
    localparam logic [OFF_W-1:0]  ONE_O = OFF_W'(1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    phase_t              phase;
    logic [3:0]          bitcnt;
    logic [BYTE_W-1:0]   shreg;
    logic [ADDR_W-1:0]   ptr;
    logic [PG_W-1:0]     page;
    logic [OFF_W-1:0]    woff;
    logic                in_ack;
    logic                mack;
    logic                got_data;
    logic                pull;
    logic                commit_go;
    logic                bw_en;
    logic [OFF_W-1:0]    bw_idx;
    logic [BYTE_W-1:0]   bw_data;
    logic                buf_clr;

    logic                wc_busy;
    logic                wc_slot_we;
    logic [OFF_W-1:0]    wc_idx;
    logic [BYTE_W-1:0]   buf_rd;
    logic [PAGE_DEPTH-1:0] buf_valid;
    logic [BYTE_W-1:0]   mem_rd;
    logic                mem_we;
    logic [2:0]          bsel;
    logic                sel_hit;
    logic                commit_ok;

    eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_page_buf #(.DW(BYTE_W), .DEPTH(PAGE_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(bw_en),
        .wr_idx(bw_idx), .wr_data(bw_data), .rd_idx(wc_idx),
        .rd_data(buf_rd), .valid(buf_valid)
    );

    eep_wcycle #(.WR_CYCLES(WR_CYCLES), .DEPTH(PAGE_DEPTH)) u_wc (
        .clk(clk), .rst_n(rst_n), .start(commit_go), .busy(wc_busy),
        .slot_we(wc_slot_we), .slot_idx(wc_idx)
    );

    eep_array #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr({page, wc_idx}),
        .wdata(buf_rd), .raddr(ptr), .rdata(mem_rd)
    );

    // Purpose: drain valid buffer entries into the array unless supply is low.
    assign mem_we = wc_slot_we & buf_valid[wc_idx] & ~vlow_i;

    // Purpose: pick the outgoing read bit for the current bit count.
    assign bsel = 3'd7 - bitcnt[2:0];

    // Purpose: select byte match against type code, strap bits and busy state.
    assign sel_hit = (shreg[7:1] == {DEV_TYPE, chip_sel_i}) && !wc_busy;

    // Purpose: a STOP may commit only after whole data bytes and with no veto.
    assign commit_ok = (phase == PH_WDATA) && got_data && !in_ack &&
                       (bitcnt <= 4'd1) && !wp_i && !vlow_i;

    // Purpose: bus protocol sequencer for select, address, write and read phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            page      <= '0;
            woff      <= '0;
            in_ack    <= 1'b0;
            mack      <= 1'b0;
            got_data  <= 1'b0;
            pull      <= 1'b0;
            commit_go <= 1'b0;
            bw_en     <= 1'b0;
            bw_idx    <= '0;
            bw_data   <= '0;
            buf_clr   <= 1'b0;
        end else begin
            commit_go <= 1'b0;
            bw_en     <= 1'b0;
            buf_clr   <= 1'b0;
            if (start_det) begin
                phase  <= PH_DEV;
                bitcnt <= '0;
                in_ack <= 1'b0;
                pull   <= 1'b0;
            end else if (stop_det) begin
                commit_go <= commit_ok;
                phase     <= PH_IDLE;
                in_ack    <= 1'b0;
                pull      <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise && !in_ack) begin
                    if (phase == PH_RDATA) begin
                        if (bitcnt < 4'd8) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (bitcnt == 4'd8) begin
                            mack   <= ~sda_s;
                            bitcnt <= 4'd9;
                        end
                    end else if (bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                end else if (scl_fall) begin
                    if (in_ack) begin
                        in_ack <= 1'b0;
                        bitcnt <= '0;
                        if (phase == PH_RDATA) begin
                            shreg <= mem_rd;
                            pull  <= ~mem_rd[7];
                            ptr   <= ptr + ONE_A;
                        end else begin
                            pull <= 1'b0;
                        end
                    end else if (phase == PH_RDATA) begin
                        if (bitcnt == 4'd9) begin
                            if (mack) begin
                                bitcnt <= '0;
                                shreg  <= mem_rd;
                                pull   <= ~mem_rd[7];
                                ptr    <= ptr + ONE_A;
                            end else begin
                                phase <= PH_IDLE;
                                pull  <= 1'b0;
                            end
                        end else if (bitcnt == 4'd8) begin
                            pull <= 1'b0;
                        end else if (bitcnt != 4'd0) begin
                            pull <= ~shreg[bsel];
                        end
                    end else if (bitcnt == 4'd8) begin
                        unique case (phase)
                            PH_DEV: begin
                                if (sel_hit) begin
                                    pull   <= 1'b1;
                                    in_ack <= 1'b1;
                                    phase  <= shreg[0] ? PH_RDATA : PH_ADDR;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_ADDR: begin
                                ptr      <= shreg[ADDR_W-1:0];
                                page     <= shreg[ADDR_W-1:OFF_W];
                                woff     <= shreg[OFF_W-1:0];
                                got_data <= 1'b0;
                                buf_clr  <= 1'b1;
                                pull     <= 1'b1;
                                in_ack   <= 1'b1;
                                phase    <= PH_WDATA;
                            end
                            PH_WDATA: begin
                                bw_en    <= 1'b1;
                                bw_idx   <= woff;
                                bw_data  <= shreg;
                                woff     <= woff + ONE_O;
                                ptr      <= {page, woff + ONE_O};
                                got_data <= 1'b1;
                                pull     <= 1'b1;
                                in_ack   <= 1'b1;
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
            end
        end
    end

    assign sda_pull_o = pull;
endmodule

// File: rtl/eep_checker.sv
// Module: eep_checker
// Temporal checks on the serial memory slave, attached by bind.
// Assumes: the bound signals come from the sync stage, the programming timer
// and the port list of the slave.
module eep_checker (
    input logic clk,
    input logic rst_n,
    input logic wp_i,
    input logic vlow_i,
    input logic sda_pull_o,
    input logic scl_s,
    input logic stop_det,
    input logic busy,
    input logic mem_we
);
    // R5: the data line pull only moves while the synchronized clock is low
    a_r5_pull_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !$past(scl_s));

    // R9: no acknowledge or data drive while the programming window runs
    a_r9_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    // R3 and R4: a programming window opens only when no veto was present at STOP
    a_r3_r4_no_veto_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!wp_i && !vlow_i, 2));

    // R8: a programming window is always preceded by a STOP condition
    a_r8_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det, 2));

    // R4: no array write while the supply is flagged low
    a_r4_no_write_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
        vlow_i |-> !mem_we);
endmodule

bind i2c_eeprom_slave eep_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .vlow_i(vlow_i),
    .sda_pull_o(sda_pull_o), .scl_s(scl_s), .stop_det(stop_det),
    .busy(wc_busy), .mem_we(mem_we)
);

// File: tb/i2c_eeprom_slave_bench.sv
// Bench: drives the bus as a master through an open-drain model and checks
// acknowledges and read data against expectations derived from the requirements.
module i2c_eeprom_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WR         = 300;
    localparam int H          = 8;
    localparam int Q          = 2;
    localparam logic [2:0] SEL = 3'b011;
    localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

    // table entry: {is_read, word address, data}
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 8'h00, 8'h5A}, {1'b0, 8'hFF, 8'hC3},
        {1'b0, 8'h7E, 8'h00}, {1'b0, 8'h81, 8'hA5},
        {1'b1, 8'h81, 8'hA5}, {1'b1, 8'h00, 8'h5A},
        {1'b1, 8'hFF, 8'hC3}, {1'b1, 8'h7E, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic vlow = 1'b0;
    logic sda_pull;
    logic sda_bus;
    int   n_chk = 0;
    int   n_err = 0;
    logic done = 1'b0;

    assign sda_bus = sda_m & ~sda_pull;

    i2c_eeprom_slave #(.WR_CYCLES(WR)) u_i2c_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .chip_sel_i(SEL), .wp_i(wp), .vlow_i(vlow), .sda_pull_o(sda_pull)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H / 2);
        ack = ~sda_bus; tick(H / 2); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H); scl_m = 1'b1; tick(H / 2); b[i] = sda_bus;
            tick(H / 2); scl_m = 1'b0; tick(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(H);
        scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
    endtask

    // select plus word address, leaving the bus inside the write transaction
    task automatic set_addr(input logic [7:0] a, output logic ack);
        logic k;
        bus_start; send_byte(DEV_W, ack); send_byte(a, k); ack = ack & k;
    endtask

    task automatic write_one(input logic [7:0] a, input logic [7:0] d, output logic ack);
        logic k;
        set_addr(a, ack); send_byte(d, k); ack = ack & k; bus_stop;
    endtask

    task automatic read_first(input logic [7:0] a);
        logic k;
        set_addr(a, k); bus_start; send_byte(DEV_R, k);
    endtask

    task automatic probe(output logic ack);
        bus_start; send_byte(DEV_W, ack); bus_stop;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic       ack;
        logic [7:0] rd;
        tick(5);
        chk("R5 pull idle in reset", 32'(sda_pull), 32'd0);
        rst_n = 1'b1;
        tick(5);
        chk("R5 pull idle after reset", 32'(sda_pull), 32'd0);

        // R1: erased state read
        read_first(8'h42); recv_byte(rd, 1'b0); bus_stop;
        chk("R1 erased location", 32'(rd), 32'hFF);

        // R1: table of writes and reads
        for (int i = 0; i < 8; i++) begin
            if (!VEC[i][16]) begin
                write_one(VEC[i][15:8], VEC[i][7:0], ack);
                chk("R1 write acks", 32'(ack), 32'd1);
                tick(WR + 40);
            end else begin
                read_first(VEC[i][15:8]); recv_byte(rd, 1'b0); bus_stop;
                chk("R1 read back", 32'(rd), 32'(VEC[i][7:0]));
            end
        end

        // R2: wrong type code and wrong strap bits are ignored
        bus_start; send_byte(8'hB6, ack); bus_stop;
        chk("R2 wrong type nack", 32'(ack), 32'd0);
        bus_start; send_byte(8'hA0, ack); bus_stop;
        chk("R2 wrong strap nack", 32'(ack), 32'd0);
        probe(ack);
        chk("R2 matching select ack", 32'(ack), 32'd1);

        // R9: select during programming window is not acknowledged
        write_one(8'h20, 8'h77, ack);
        tick(20);
        probe(ack);
        chk("R9 nack while busy", 32'(ack), 32'd0);
        tick(WR + 40);
        probe(ack);
        chk("R9 ack after window", 32'(ack), 32'd1);
        read_first(8'h20); recv_byte(rd, 1'b0); bus_stop;
        chk("R9 committed data", 32'(rd), 32'h77);

        // R10: sequential read wraps from FF to 00
        read_first(8'hFE);
        recv_byte(rd, 1'b1); chk("R10 byte at FE", 32'(rd), 32'hFF);
        recv_byte(rd, 1'b1); chk("R10 byte at FF", 32'(rd), 32'hC3);
        recv_byte(rd, 1'b1); chk("R10 wrap to 00", 32'(rd), 32'h5A);
        recv_byte(rd, 1'b0); chk("R10 byte at 01", 32'(rd), 32'hFF);
        bus_stop;

        // R6: page write starting mid page wraps inside the page
        set_addr(8'h35, ack);
        for (int i = 0; i < 16; i++) send_byte(8'(8'h10 + i), ack);
        bus_stop; tick(WR + 40);
        read_first(8'h30);
        for (int j = 0; j < 16; j++) begin
            recv_byte(rd, j != 15);
            chk("R6 page wrap", 32'(rd), 32'(8'h10 + ((j + 11) & 15)));
        end
        bus_stop;

        // R7: bytes beyond sixteen overwrite earlier entries
        set_addr(8'h40, ack);
        for (int i = 0; i < 18; i++) send_byte(8'(8'h80 + i), ack);
        bus_stop; tick(WR + 40);
        read_first(8'h40);
        for (int j = 0; j < 16; j++) begin
            recv_byte(rd, j != 15);
            chk("R7 overflow", 32'(rd), 32'(j < 2 ? 8'h90 + j : 8'h80 + j));
        end
        bus_stop;

        // R3: write protect keeps data, still acknowledges, opens no window
        wp = 1'b1;
        write_one(8'h00, 8'h11, ack);
        chk("R3 data ack under protect", 32'(ack), 32'd1);
        probe(ack);
        chk("R3 no window under protect", 32'(ack), 32'd1);
        wp = 1'b0;
        read_first(8'h00); recv_byte(rd, 1'b0); bus_stop;
        chk("R3 data unchanged", 32'(rd), 32'h5A);

        // R4: low supply lockout keeps data
        vlow = 1'b1;
        write_one(8'hFF, 8'h22, ack);
        chk("R4 data ack under lockout", 32'(ack), 32'd1);
        probe(ack);
        chk("R4 no window under lockout", 32'(ack), 32'd1);
        vlow = 1'b0;
        read_first(8'hFF); recv_byte(rd, 1'b0); bus_stop;
        chk("R4 data unchanged", 32'(rd), 32'hC3);

        // R8: STOP inside a data byte discards the whole transaction
        set_addr(8'h50, ack); send_byte(8'h33, ack); send_bits(8'hFF, 3); bus_stop;
        probe(ack);
        chk("R8 partial byte no window", 32'(ack), 32'd1);
        read_first(8'h50); recv_byte(rd, 1'b0); bus_stop;
        chk("R8 partial byte no write", 32'(rd), 32'hFF);

        // R8: address only write starts nothing
        set_addr(8'h51, ack); bus_stop;
        probe(ack);
        chk("R8 address only no window", 32'(ack), 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule